// File: doc/BRIEF.md
# Random Number Generator Control Front-End

This block is the register-mapped control and event front-end of a hardware random number generator. Software drives it over a simple 32-bit register bus. Command pulses start a self-test or a seed operation. A control register enables automatic reseeding and masks the two interrupt sources. A status register reports the completion flags, the error flag and the fill level of an output word queue, and a data port pops one generated word per read.

The entropy source and the conditioning core are replaced by a stub. Each operation takes a fixed number of cycles. Output words come from a 32-bit shift-register generator, and a test input forces the running operation to fail when it completes. Once a seed has succeeded, the queue refills by one word per cycle. Refill pauses while an operation runs and stops while an error is pending.

Interrupt handling follows a two-level clear scheme. Clearing the interrupt removes only the completion flags, and only when no error is recorded. Clearing the error wipes the error state together with the completion flags.

Top module: `trng_frontend`

## Requirements
- R1: A read of offset 0x00 returns the identity word: the type code (default 0x2) in bits 31:28, the major revision (default 0x01) in bits 15:8, the minor revision (default 0x03) in bits 7:0, and zeros elsewhere.
- R2: A write to offset 0x04 with bit 0 set, while no operation runs, starts a self-test lasting TEST_LAT cycles, after which status bit 4 is set. Command bits are pulses, and a read of 0x04 always returns 0.
- R3: A write to 0x04 with bit 1 set, while idle, starts a seed operation lasting SEED_LAT cycles, after which status bit 5 is set. After a successful seed the queue fills by one word per cycle up to FIFO_DEPTH, and the level is reported in status bits 12:8.
- R4: A read of offset 0x14 returns the oldest queued word and lowers the level by one. The words are successive states s' = (s >> 1) ^ (s[0] ? 0x80200003 : 0), starting from the state 1, and the first word is the state after one step. A read while the queue is empty returns 0 and leaves the level at 0.
- R5: The control register at 0x08 holds auto-reseed (bit 4), done mask (bit 5) and error mask (bit 6) and reads back. The irq output is registered and equals, one cycle late, (self-test done or seed done, with the done mask clear) or (error, with the error mask clear).
- R6: Command bit 4 clears both completion flags only while no error is pending. While an error is pending it has no effect.
- R7: Command bit 5 clears the error flag, the error register (offset 0x10) and both completion flags.
- R8: If fault_inject is high when an operation completes, status bit 16 is set and the error register reads 0x8 for a seed or 0x1 for a self-test. A failed seed does not mark the generator seeded, and no word is queued while the error is pending.
- R9: With auto-reseed enabled, the RESEED_WORDS-th word popped since the last wrap of the served-word count launches a seed without software, and it completes with status bit 5. With auto-reseed disabled, popping words launches nothing.
- R10: Start commands written while an operation runs are ignored. When bits 0 and 1 are written together, only the self-test runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears the next cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Registered interrupt request |
| fault_inject | input | 1 | Test input that fails the operation completing in this cycle |

## Verification
The hardest state to reach is an error that is pending while a completion flag is set and the queue still holds words. It is needed to show that the interrupt clear is gated and that refill stops. The bench reaches it by holding fault_inject high across a whole seed operation after a good seed has filled the queue. It then issues an interrupt clear and drains every word. Automatic reseeding is reached by overriding RESEED_WORDS to a small count and popping that many words, first with the enable off and then with it on.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] OFF_IDENT = 8'h00;
  localparam logic [7:0] OFF_CMD   = 8'h04;
  localparam logic [7:0] OFF_CTRL  = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h0C;
  localparam logic [7:0] OFF_ERR   = 8'h10;
  localparam logic [7:0] OFF_DATA  = 8'h14;

  localparam int CMD_TEST   = 0;
  localparam int CMD_SEED   = 1;
  localparam int CMD_CLRINT = 4;
  localparam int CMD_CLRERR = 5;

  localparam int CTL_AUTO  = 4;
  localparam int CTL_MDONE = 5;
  localparam int CTL_MERR  = 6;

  localparam int STS_TDONE = 4;
  localparam int STS_SDONE = 5;
  localparam int STS_LVL   = 8;
  localparam int STS_ERR   = 16;

  localparam logic [3:0] ERRC_TEST = 4'h1;
  localparam logic [3:0] ERRC_STAT = 4'h8;

  typedef enum logic [1:0] {OP_IDLE, OP_TEST, OP_SEED} op_e;

  function automatic logic [31:0] lfsr_adv(input logic [31:0] s, input logic [31:0] taps);
    return {1'b0, s[31:1]} ^ (s[0] ? taps : 32'h0);
  endfunction
endpackage

// File: rtl/trng_source.sv
module trng_source #(
  parameter logic [31:0] TAPS = 32'h8020_0003,
  parameter logic [31:0] INIT = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adv,
  output logic [31:0] word
);
  import trng_pkg::*;

  logic [31:0] state_q;

  assign word = lfsr_adv(state_q, TAPS);

  always_ff @(posedge clk) begin
    if (rst)      state_q <= INIT;
    else if (adv) state_q <= word;
  end
endmodule

// File: rtl/trng_seq.sv
module trng_seq #(
  parameter int TEST_LAT = 12,
  parameter int SEED_LAT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start_test,
  input  logic start_seed,
  input  logic fault_in,
  output logic idle,
  output logic fin_test,
  output logic fin_seed,
  output logic fin_fail
);
  import trng_pkg::*;

  localparam int MAXLAT = (TEST_LAT > SEED_LAT) ? TEST_LAT : SEED_LAT;
  localparam int CW     = $clog2(MAXLAT + 1);

  op_e           op_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign idle     = (op_q == OP_IDLE);
  assign last     = !idle && (cnt_q == '0);
  assign fin_test = last && (op_q == OP_TEST);
  assign fin_seed = last && (op_q == OP_SEED);
  assign fin_fail = last && fault_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (idle) begin
      if (start_test) begin
        op_q  <= OP_TEST;
        cnt_q <= CW'(TEST_LAT - 1);
      end else if (start_seed) begin
        op_q  <= OP_SEED;
        cnt_q <= CW'(SEED_LAT - 1);
      end
    end else if (last) begin
      op_q <= OP_IDLE;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/trng_fifo.sv
module trng_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_req,
  input  logic             pop,
  output logic [WIDTH-1:0] q,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [WIDTH-1:0] q_mem;
  logic             empty_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
    if (pop)  q_mem <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level   <= '0;
      empty_q <= 1'b1;
    end else begin
      if (push) wptr_q <= wrap_inc(wptr_q);
      if (pop)  rptr_q <= wrap_inc(rptr_q);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
      if (rd_req) empty_q <= !pop;
    end
  end

  assign q = empty_q ? '0 : q_mem;
endmodule

// File: rtl/trng_frontend.sv
module trng_frontend #(
  parameter int          ADDR_W       = 8,
  parameter int          FIFO_DEPTH   = 16,
  parameter int          TEST_LAT     = 12,
  parameter int          SEED_LAT     = 20,
  parameter int          RESEED_WORDS = 1 << 20,
  parameter logic [3:0]  VER_TYPE     = 4'h2,
  parameter logic [7:0]  VER_MAJOR    = 8'h01,
  parameter logic [7:0]  VER_MINOR    = 8'h03,
  parameter logic [31:0] LFSR_TAPS    = 32'h8020_0003,
  parameter logic [31:0] LFSR_INIT    = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              fault_inject
);
  import trng_pkg::*;

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int CNT_W = $clog2(RESEED_WORDS + 1);

  logic wr_cmd, wr_ctrl, rd_data;
  logic cmd_test, cmd_seed, cmd_clrint, cmd_clrerr;
  logic seq_idle, fin_test, fin_seed, fin_fail;
  logic start_test, start_seed;
  logic test_done, seed_done, err_flag, seeded;
  logic [3:0] err_code;
  logic auto_en, mask_done, mask_err;
  logic reseed_pend;
  logic [CNT_W-1:0] served_q;
  logic [LVL_W-1:0] fifo_level;
  logic [31:0] fifo_q, src_word, reg_q, sts_word;
  logic push, pop, sel_fifo;
  logic unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:7], bus_wdata[3:2]};

  assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign rd_data = bus_rd && (bus_addr == ADDR_W'(OFF_DATA));

  assign cmd_test   = wr_cmd && bus_wdata[CMD_TEST];
  assign cmd_seed   = wr_cmd && bus_wdata[CMD_SEED];
  assign cmd_clrint = wr_cmd && bus_wdata[CMD_CLRINT];
  assign cmd_clrerr = wr_cmd && bus_wdata[CMD_CLRERR];

  assign start_test = seq_idle && cmd_test;
  assign start_seed = seq_idle && !cmd_test && (cmd_seed || reseed_pend);

  assign pop  = rd_data && (fifo_level != '0);
  assign push = seeded && !err_flag && seq_idle && (fifo_level < LVL_W'(FIFO_DEPTH));

  trng_seq #(.TEST_LAT(TEST_LAT), .SEED_LAT(SEED_LAT)) seq_i (
    .clk(clk), .rst(rst),
    .start_test(start_test), .start_seed(start_seed), .fault_in(fault_inject),
    .idle(seq_idle), .fin_test(fin_test), .fin_seed(fin_seed), .fin_fail(fin_fail)
  );

  trng_source #(.TAPS(LFSR_TAPS), .INIT(LFSR_INIT)) src_i (
    .clk(clk), .rst(rst), .adv(push), .word(src_word)
  );

  trng_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) fifo_i (
    .clk(clk), .rst(rst), .push(push), .wdata(src_word),
    .rd_req(rd_data), .pop(pop), .q(fifo_q), .level(fifo_level)
  );

  // event flags: clears first, completions override
  always_ff @(posedge clk) begin
    if (rst) begin
      test_done <= 1'b0;
      seed_done <= 1'b0;
      err_flag  <= 1'b0;
      err_code  <= '0;
      seeded    <= 1'b0;
    end else begin
      if (cmd_clrerr) begin
        err_flag  <= 1'b0;
        err_code  <= '0;
        test_done <= 1'b0;
        seed_done <= 1'b0;
      end else if (cmd_clrint && !err_flag) begin
        test_done <= 1'b0;
        seed_done <= 1'b0;
      end
      if (fin_test) begin
        test_done <= 1'b1;
        if (fin_fail) begin
          err_flag <= 1'b1;
          err_code <= ERRC_TEST;
        end
      end
      if (fin_seed) begin
        seed_done <= 1'b1;
        if (fin_fail) begin
          err_flag <= 1'b1;
          err_code <= ERRC_STAT;
        end else begin
          seeded <= 1'b1;
        end
      end
    end
  end

  // control register and served-word reseed counter
  always_ff @(posedge clk) begin
    if (rst) begin
      auto_en     <= 1'b0;
      mask_done   <= 1'b0;
      mask_err    <= 1'b0;
      served_q    <= '0;
      reseed_pend <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        auto_en   <= bus_wdata[CTL_AUTO];
        mask_done <= bus_wdata[CTL_MDONE];
        mask_err  <= bus_wdata[CTL_MERR];
      end
      if (start_seed) reseed_pend <= 1'b0;
      if (pop) begin
        if (served_q == CNT_W'(RESEED_WORDS - 1)) begin
          served_q <= '0;
          if (auto_en) reseed_pend <= 1'b1;
        end else begin
          served_q <= served_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ((test_done || seed_done) && !mask_done) || (err_flag && !mask_err);
  end

  always_comb begin
    sts_word = '0;
    sts_word[STS_TDONE] = test_done;
    sts_word[STS_SDONE] = seed_done;
    sts_word[STS_LVL +: LVL_W] = fifo_level;
    sts_word[STS_ERR] = err_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= '0;
      sel_fifo <= 1'b0;
    end else if (bus_rd) begin
      sel_fifo <= (bus_addr == ADDR_W'(OFF_DATA));
      if (bus_addr == ADDR_W'(OFF_IDENT))
        reg_q <= {VER_TYPE, 12'h000, VER_MAJOR, VER_MINOR};
      else if (bus_addr == ADDR_W'(OFF_CTRL))
        reg_q <= {25'd0, mask_err, mask_done, auto_en, 4'd0};
      else if (bus_addr == ADDR_W'(OFF_STAT))
        reg_q <= sts_word;
      else if (bus_addr == ADDR_W'(OFF_ERR))
        reg_q <= {28'd0, err_code};
      else
        reg_q <= '0;
    end
  end

  assign bus_rdata = sel_fifo ? fifo_q : reg_q;
endmodule

// File: rtl/trng_frontend_chk.sv
module trng_frontend_chk #(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_cmd,
  input logic [31:0]      bus_wdata,
  input logic             seq_idle,
  input logic             irq,
  input logic             test_done,
  input logic             seed_done,
  input logic             err_flag,
  input logic [3:0]       err_code,
  input logic             mask_done,
  input logic [LVL_W-1:0] fifo_level
);
  // R5
  irq_done_chk: assert property (@(posedge clk) disable iff (rst)
    ((test_done || seed_done) && !mask_done) |=> irq);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!test_done && !seed_done && !err_flag) |=> !irq);

  // R6
  clrint_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && bus_wdata[4] && !bus_wdata[5] && err_flag && seed_done) |=> seed_done);

  // R7
  clrerr_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && bus_wdata[5] && seq_idle) |=> (!err_flag && err_code == 4'h0 && !test_done && !seed_done));

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LVL_W'(FIFO_DEPTH));

  // R8
  no_refill_err_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> fifo_level <= $past(fifo_level));
endmodule

bind trng_frontend trng_frontend_chk #(
  .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .bus_wdata(bus_wdata),
  .seq_idle(seq_idle), .irq(irq), .test_done(test_done), .seed_done(seed_done),
  .err_flag(err_flag), .err_code(err_code), .mask_done(mask_done),
  .fifo_level(fifo_level)
);

// File: tb/trng_frontend_tb_top.sv
`timescale 1ns/1ps
module trng_frontend_tb_top;
  localparam int DEPTH = 16;
  localparam int TL    = 12;
  localparam int SL    = 20;
  localparam int RW    = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0, fault = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  trng_frontend #(
    .ADDR_W(8), .FIFO_DEPTH(DEPTH), .TEST_LAT(TL), .SEED_LAT(SL), .RESEED_WORDS(RW)
  ) dut_i (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rdata), .irq(irq), .fault_inject(fault)
  );

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_op, m_cnt, m_served;
  bit          m_td, m_sd, m_err, m_seeded, m_pend, m_auto, m_md, m_me, m_irq, m_rv;
  logic [3:0]  m_code;
  logic [31:0] m_lfsr, m_rdata;
  logic [31:0] m_q[$];
  string       m_tag;

  always @(posedge clk) begin
    if (rst) begin
      m_op = 0; m_cnt = 0; m_served = 0;
      m_td = 0; m_sd = 0; m_err = 0; m_seeded = 0; m_pend = 0;
      m_auto = 0; m_md = 0; m_me = 0; m_irq = 0; m_rv = 0;
      m_code = 0; m_lfsr = 32'h1; m_rdata = 0; m_q.delete();
    end else begin
      bit idle, cw, fin, pop, push, st_t, st_s, irq_n;
      m_rv = rd;
      if (rd) begin
        case (addr)
          8'h00: begin m_rdata = 32'h2000_0103; m_tag = "R1 ident"; end
          8'h04: begin m_rdata = 0; m_tag = "R2 cmd read"; end
          8'h08: begin m_rdata = {25'd0, m_me, m_md, m_auto, 4'd0}; m_tag = "R5 ctrl"; end
          8'h0C: begin
            m_rdata = (32'(m_err) << 16) | (32'(m_q.size()) << 8) | (32'(m_sd) << 5) | (32'(m_td) << 4);
            m_tag = "R3 status";
          end
          8'h10: begin m_rdata = {28'd0, m_code}; m_tag = "R8 error"; end
          8'h14: begin m_rdata = (m_q.size() > 0) ? m_q[0] : 32'h0; m_tag = "R4 data"; end
          default: begin m_rdata = 0; m_tag = "R1 unmapped"; end
        endcase
      end
      irq_n = ((m_td || m_sd) && !m_md) || (m_err && !m_me);
      idle  = (m_op == 0);
      cw    = wr && addr == 8'h04;
      fin   = !idle && m_cnt == 0;
      pop   = rd && addr == 8'h14 && m_q.size() > 0;
      push  = m_seeded && !m_err && idle && m_q.size() < DEPTH;
      st_t  = idle && cw && wd[0];
      st_s  = idle && !(cw && wd[0]) && ((cw && wd[1]) || m_pend);
      if (cw && wd[5]) begin m_err = 0; m_code = 0; m_td = 0; m_sd = 0; end
      else if (cw && wd[4] && !m_err) begin m_td = 0; m_sd = 0; end
      if (fin) begin
        if (m_op == 1) begin
          m_td = 1;
          if (fault) begin m_err = 1; m_code = 4'h1; end
        end else begin
          m_sd = 1;
          if (fault) begin m_err = 1; m_code = 4'h8; end
          else m_seeded = 1;
        end
        m_op = 0;
      end else if (!idle) m_cnt--;
      else if (st_t) begin m_op = 1; m_cnt = TL - 1; end
      else if (st_s) begin m_op = 2; m_cnt = SL - 1; end
      if (pop) void'(m_q.pop_front());
      if (push) begin m_lfsr = lfsr_next(m_lfsr); m_q.push_back(m_lfsr); end
      if (st_s) m_pend = 0;
      if (pop) begin
        if (m_served == RW - 1) begin m_served = 0; if (m_auto) m_pend = 1; end
        else m_served++;
      end
      if (wr && addr == 8'h08) begin m_auto = wd[4]; m_md = wd[5]; m_me = wd[6]; end
      m_irq = irq_n;
    end
  end

  // compare on every clock, a quarter period after the edge
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      chk("R5 irq per-cycle", {31'd0, irq}, {31'd0, m_irq});
      if (m_rv) chk(m_tag, rdata, m_rdata);
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wd = d;
    @(negedge clk); wr = 1'b0; wd = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run();
    logic [31:0] v, w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle_n(2);
    chk("R5 irq after reset", {31'd0, irq}, 32'd0);
    bus_read(8'h00, v); chk("R1 ident word", v, 32'h2000_0103);
    bus_read(8'h04, v); chk("R2 cmd reads zero", v, 32'h0);
    bus_read(8'h0C, v); chk("R3 status at reset", v, 32'h0);
    bus_read(8'h14, v); chk("R4 empty read zero", v, 32'h0);
    bus_read(8'h0C, v); chk("R4 empty level stays 0", v, 32'h0);

    bus_write(8'h04, 32'h1); idle_n(TL + 6);
    bus_read(8'h0C, v); chk("R2 self-test done", v, 32'h10);
    chk("R5 irq on done", {31'd0, irq}, 32'd1);
    bus_write(8'h04, 32'h10); idle_n(3);
    bus_read(8'h0C, v); chk("R6 clear int no error", v, 32'h0);
    chk("R6 irq dropped", {31'd0, irq}, 32'd0);

    bus_write(8'h08, 32'h20); bus_write(8'h04, 32'h2); idle_n(SL + DEPTH + 8);
    bus_read(8'h08, v); chk("R5 ctrl readback", v, 32'h20);
    bus_read(8'h0C, v); chk("R3 seeded and full", v, 32'h1020);
    chk("R5 done masked", {31'd0, irq}, 32'd0);
    w = 32'h1;
    for (int i = 0; i < 3; i++) begin
      w = lfsr_next(w);
      bus_read(8'h14, v); chk("R4 word order", v, w);
    end

    bus_write(8'h08, 32'h0); fault = 1'b1; bus_write(8'h04, 32'h2); idle_n(SL + 5); fault = 1'b0;
    bus_read(8'h10, v); chk("R8 seed stat error code", v, 32'h8);
    bus_read(8'h0C, v); chk("R8 error flag in status", v, 32'h11020);
    chk("R5 irq on error", {31'd0, irq}, 32'd1);
    bus_write(8'h04, 32'h10); idle_n(2);
    bus_read(8'h0C, v); chk("R6 clear int ignored on error", v, 32'h11020);
    for (int i = 0; i < DEPTH; i++) bus_read(8'h14, v);
    idle_n(4);
    bus_read(8'h0C, v); chk("R8 no refill while error", v, 32'h10020);
    bus_read(8'h14, v); chk("R4 drained read zero", v, 32'h0);
    bus_write(8'h04, 32'h20); idle_n(3);
    bus_read(8'h10, v); chk("R7 error register wiped", v, 32'h0);
    chk("R7 irq dropped", {31'd0, irq}, 32'd0);
    idle_n(DEPTH + 4);
    bus_read(8'h0C, v); chk("R7 flags clear, refill resumes", v, 32'h1000);

    fault = 1'b1; bus_write(8'h04, 32'h1); idle_n(TL + 4); fault = 1'b0;
    bus_read(8'h10, v); chk("R8 self-test error code", v, 32'h1);
    bus_write(8'h04, 32'h20); idle_n(3);

    bus_write(8'h04, 32'h2); idle_n(3); bus_write(8'h04, 32'h1); idle_n(SL + 6);
    bus_read(8'h0C, v); chk("R10 test ignored while busy", v, 32'h1020);
    bus_write(8'h04, 32'h10); idle_n(TL + 6);
    bus_read(8'h0C, v); chk("R10 no late self-test", v, 32'h1000);
    bus_write(8'h04, 32'h3); idle_n(TL + 4);
    bus_read(8'h0C, v); chk("R10 test wins over seed", v, 32'h1010);
    idle_n(SL + 6);
    bus_read(8'h0C, v); chk("R10 seed never ran", v, 32'h1010);

    bus_write(8'h04, 32'h10); bus_write(8'h08, 32'h0);
    for (int i = 0; i < RW; i++) bus_read(8'h14, v);
    idle_n(SL + 10);
    bus_read(8'h0C, v); chk("R9 no reseed when disabled", v, 32'h1000);
    bus_write(8'h08, 32'h10);
    for (int i = 0; i < RW; i++) bus_read(8'h14, v);
    idle_n(SL + DEPTH + 10);
    bus_read(8'h0C, v); chk("R9 automatic reseed done", v, 32'h1020);
    idle_n(4);
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
    end
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule